// File: doc/BRIEF.md
# TDM Time-Slot Assigner Sequencer

This block routes the bit positions of a time-division-multiplexed serial frame to serial channels and strobe lines. A small routing table holds slot entries. Each entry gives a channel code, a set of strobes and a slot length counted in bits or bytes. A frame sync begins the walk at entry 0. The sequencer counts serial clock ticks for the current entry and then moves to the next one. After the entry flagged as last it goes idle until the next sync. While a slot is active, the sequencer drives a one-hot channel enable and the selected strobes. The channel controllers use these outputs to decide which serial bits belong to them.

There are two independent directions, receive and transmit. Each direction has its own table and its own walker. The serial clock reaches the block as a one-cycle tick qualifier on the system clock, and sync is taken into account only on a tick. In common-clock mode the transmit walker uses the receive tick and sync, so the two directions run in lockstep. Routing is static: the table write port is a valid/ready stream, and ready is held low for as long as the sequencer is enabled. A producer that offers a write while the sequencer is enabled is held back. It must keep valid and its data steady or withdraw the write, and nothing is stored until a handshake completes. New routing therefore applies from the first sync after the sequencer is enabled again.

Top module: `tsa_sequencer`

## Requirements
- R1: A table word is 15 bits. Bit 14 is a multichannel flag, bit 13 is a table-swap flag, bits 12:9 are the strobe select, bits 8:5 are the channel code, bits 4:2 are the count, bit 1 is the byte flag and bit 0 is the last flag. The multichannel and swap flags of the active slot appear on `*_multi` and `*_swtab`.
- R2: A slot lasts count+1 ticks when the byte flag is 0 and 8*(count+1) ticks when the byte flag is 1.
- R3: A slot with channel code k, where k is not 0, drives bit k of `*_chan_en` alone for the whole slot. Code 0 drives no enable. Bit 0 of `*_chan_en` is never set, and at most one bit is ever set.
- R4: Bit i of `*_strobe` follows bit i of the strobe select for the whole slot. Select 1000 drives strobe 1 (bit 3) and 0100 drives strobe 2 (bit 2). A strobe and a channel enable may be driven together.
- R5: When a tick arrives with sync high and the sequencer is enabled, the outputs of entry 0 appear on the clock edge that samples that tick.
- R6: When the last slot ends, meaning the entry with the last flag set or the entry at the final table address, all enables, strobes and flags go to 0 on the next tick and stay at 0 until a sync.
- R7: With the six-entry table (8 bits to channel 2, 1 bit to channel 1 with strobe 1, 1 unused bit, 4 bits on strobe 2 only, 4 bits to channel 5, 1 last bit to channel 1 with strobe 1), the frame follows that sequence over 19 ticks.
- R8: When `common_mode` is 1, the transmit walker is driven by `rx_tick` and `rx_sync`, and `tx_tick` and `tx_sync` are ignored.
- R9: `wr_ready` is 1 only while `enable` is 0. A write is stored only when `wr_valid` and `wr_ready` are both high. While `enable` is 0, all outputs stay at 0 and sync is ignored.
- R10: The outputs change only on an edge that samples a tick, or when `enable` goes low.
- R11: A sync that arrives in the middle of a frame restarts the walk at entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Sequencer enable; table writes are blocked while it is 1 |
| common_mode | input | 1 | Run transmit from the receive tick and sync |
| rx_tick | input | 1 | Receive serial clock qualifier |
| rx_sync | input | 1 | Receive frame sync, taken with rx_tick |
| tx_tick | input | 1 | Transmit serial clock qualifier |
| tx_sync | input | 1 | Transmit frame sync, taken with tx_tick |
| wr_valid | input | 1 | Table write offered |
| wr_ready | output | 1 | Table write can be accepted |
| wr_dir | input | 1 | Target table: 0 receive, 1 transmit |
| wr_addr | input | AW | Table entry address |
| wr_data | input | 15 | Table word (R1 layout) |
| rx_chan_en | output | 16 | Receive one-hot channel enable |
| rx_strobe | output | 4 | Receive strobes, bit 3 is strobe 1 |
| rx_multi | output | 1 | Receive slot multichannel flag |
| rx_swtab | output | 1 | Receive slot swap flag |
| tx_chan_en | output | 16 | Transmit one-hot channel enable |
| tx_strobe | output | 4 | Transmit strobes, bit 3 is strobe 1 |
| tx_multi | output | 1 | Transmit slot multichannel flag |
| tx_swtab | output | 1 | Transmit slot swap flag |

## Verification
Every routing output is registered once. A slot change is therefore due on the same clock edge that samples the tick that caused it, and a drop of `enable` clears the outputs on the next edge. `wr_ready` depends on `enable` with no delay. The bench keeps a reference model that expands each frame, at sync, into a queue with one record per tick. It pops one record on every sampled tick at the rising edge and compares all outputs of both directions at the falling edge that follows. Every clock is checked, so a change that comes one edge early or late is caught, and so is a missing hold between ticks.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  localparam int SSEL_W = 4;
  localparam int CSEL_W = 4;
  localparam int CNT_W  = 3;
  localparam int N_CHAN = 1 << CSEL_W;
  localparam int LEN_W  = CNT_W + 3;
  localparam int ENTRY_W = 2 + SSEL_W + CSEL_W + CNT_W + 2;

  typedef struct packed {
    logic              multi;
    logic              swtab;
    logic [SSEL_W-1:0] ssel;
    logic [CSEL_W-1:0] csel;
    logic [CNT_W-1:0]  cnt;
    logic              byt;
    logic              last;
  } slot_t;

  // ticks in slot minus one
  function automatic logic [LEN_W-1:0] slot_len_m1(input slot_t s);
    if (s.byt) return {s.cnt, 3'b111};
    else       return {3'b000, s.cnt};
  endfunction

  function automatic logic [N_CHAN-1:0] chan_onehot(input logic [CSEL_W-1:0] code);
    logic [N_CHAN-1:0] v;
    v = '0;
    for (int k = 1; k < N_CHAN; k++) begin
      if (code == CSEL_W'(k)) v[k] = 1'b1;
    end
    return v;
  endfunction
endpackage

// File: rtl/tsa_table.sv
module tsa_table
  import tsa_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  slot_t         wdata,
  input  logic [AW-1:0] raddr,
  output slot_t         rdata
);
  slot_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && ({1'b0, waddr} < (AW+1)'(DEPTH))) begin
      mem[waddr] <= wdata;
    end
  end

  always_comb begin
    if ({1'b0, raddr} < (AW+1)'(DEPTH)) rdata = mem[raddr];
    else                                rdata = '0;
  end
endmodule

// File: rtl/tsa_walker.sv
module tsa_walker
  import tsa_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              tick,
  input  logic              sync,
  output logic [AW-1:0]     rd_addr,
  input  slot_t             rd_data,
  output logic [N_CHAN-1:0] chan_en,
  output logic [SSEL_W-1:0] strobe,
  output logic              multi,
  output logic              swtab
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  logic              active_q, active_d;
  logic [AW-1:0]     ptr_q, ptr_d;
  logic [LEN_W-1:0]  remain_q, remain_d;
  logic              last_q, last_d;
  logic [N_CHAN-1:0] chan_q, chan_d;
  logic [SSEL_W-1:0] strb_q, strb_d;
  logic              multi_q, multi_d;
  logic              swtab_q, swtab_d;
  logic              do_load, do_clear;

  // next entry: entry 0 on sync, otherwise the one after the current
  always_comb begin
    if (sync) rd_addr = '0;
    else      rd_addr = ptr_q + 1'b1;
  end

  always_comb begin
    do_load  = 1'b0;
    do_clear = 1'b0;
    if (!enable) begin
      do_clear = 1'b1;
    end else if (tick) begin
      if (sync) begin
        do_load = 1'b1;
      end else if (active_q && (remain_q == '0)) begin
        if (last_q || (ptr_q == LAST_ADDR)) do_clear = 1'b1;
        else                                do_load  = 1'b1;
      end
    end
  end

  always_comb begin
    active_d = active_q;
    ptr_d    = ptr_q;
    remain_d = remain_q;
    last_d   = last_q;
    chan_d   = chan_q;
    strb_d   = strb_q;
    multi_d  = multi_q;
    swtab_d  = swtab_q;
    if (do_clear) begin
      active_d = 1'b0;
      ptr_d    = '0;
      remain_d = '0;
      last_d   = 1'b0;
      chan_d   = '0;
      strb_d   = '0;
      multi_d  = 1'b0;
      swtab_d  = 1'b0;
    end else if (do_load) begin
      active_d = 1'b1;
      ptr_d    = rd_addr;
      remain_d = slot_len_m1(rd_data);
      last_d   = rd_data.last;
      chan_d   = chan_onehot(rd_data.csel);
      strb_d   = rd_data.ssel;
      multi_d  = rd_data.multi;
      swtab_d  = rd_data.swtab;
    end else if (enable && tick && active_q) begin
      remain_d = remain_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      ptr_q    <= '0;
      remain_q <= '0;
      last_q   <= 1'b0;
      chan_q   <= '0;
      strb_q   <= '0;
      multi_q  <= 1'b0;
      swtab_q  <= 1'b0;
    end else begin
      active_q <= active_d;
      ptr_q    <= ptr_d;
      remain_q <= remain_d;
      last_q   <= last_d;
      chan_q   <= chan_d;
      strb_q   <= strb_d;
      multi_q  <= multi_d;
      swtab_q  <= swtab_d;
    end
  end

  assign chan_en = chan_q;
  assign strobe  = strb_q;
  assign multi   = multi_q;
  assign swtab   = swtab_q;
endmodule

// File: rtl/tsa_sequencer.sv
module tsa_sequencer
  import tsa_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               common_mode,
  input  logic               rx_tick,
  input  logic               rx_sync,
  input  logic               tx_tick,
  input  logic               tx_sync,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic               wr_dir,
  input  logic [AW-1:0]      wr_addr,
  input  logic [ENTRY_W-1:0] wr_data,
  output logic [N_CHAN-1:0]  rx_chan_en,
  output logic [SSEL_W-1:0]  rx_strobe,
  output logic               rx_multi,
  output logic               rx_swtab,
  output logic [N_CHAN-1:0]  tx_chan_en,
  output logic [SSEL_W-1:0]  tx_strobe,
  output logic               tx_multi,
  output logic               tx_swtab
);
  localparam int N_DIR = 2;

  logic [N_DIR-1:0]  tick_d;
  logic [N_DIR-1:0]  sync_d;
  logic [N_DIR-1:0]  we_d;
  logic [N_CHAN-1:0] chan_d  [N_DIR];
  logic [SSEL_W-1:0] strb_d  [N_DIR];
  logic [N_DIR-1:0]  multi_d;
  logic [N_DIR-1:0]  swtab_d;
  logic              accept;

  // static routing: writes only while the sequencer is stopped
  assign wr_ready = !enable;
  assign accept   = wr_valid && wr_ready;

  assign tick_d[0] = rx_tick;
  assign sync_d[0] = rx_sync;
  assign tick_d[1] = common_mode ? rx_tick : tx_tick;
  assign sync_d[1] = common_mode ? rx_sync : tx_sync;

  generate
    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
      logic [AW-1:0] raddr;
      slot_t         rdata;

      assign we_d[d] = accept && (wr_dir == d[0]);

      tsa_table #(.DEPTH(DEPTH), .AW(AW)) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we_d[d]),
        .waddr (wr_addr),
        .wdata (slot_t'(wr_data)),
        .raddr (raddr),
        .rdata (rdata)
      );

      tsa_walker #(.DEPTH(DEPTH), .AW(AW)) u_walker (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .tick    (tick_d[d]),
        .sync    (sync_d[d]),
        .rd_addr (raddr),
        .rd_data (rdata),
        .chan_en (chan_d[d]),
        .strobe  (strb_d[d]),
        .multi   (multi_d[d]),
        .swtab   (swtab_d[d])
      );
    end
  endgenerate

  assign rx_chan_en = chan_d[0];
  assign rx_strobe  = strb_d[0];
  assign rx_multi   = multi_d[0];
  assign rx_swtab   = swtab_d[0];
  assign tx_chan_en = chan_d[1];
  assign tx_strobe  = strb_d[1];
  assign tx_multi   = multi_d[1];
  assign tx_swtab   = swtab_d[1];
endmodule

// File: rtl/tsa_sequencer_chk.sv
module tsa_sequencer_chk
  import tsa_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              common_mode,
  input logic              rx_tick,
  input logic              tx_tick,
  input logic [N_CHAN-1:0] rx_chan_en,
  input logic [SSEL_W-1:0] rx_strobe,
  input logic [N_CHAN-1:0] tx_chan_en,
  input logic [SSEL_W-1:0] tx_strobe
);
  // R3: code 0 never raises an enable
  p_no_chan0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_chan_en[0] && !tx_chan_en[0]);

  // R3: at most one channel served per slot
  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_chan_en) && $onehot0(tx_chan_en));

  // R9: stopped sequencer drives nothing
  p_off_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (rx_chan_en == '0) && (tx_chan_en == '0) &&
                (rx_strobe == '0) && (tx_strobe == '0));

  // R10: receive outputs hold between ticks
  p_rx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !rx_tick) |=> $stable(rx_chan_en) && $stable(rx_strobe));

  // R10 and R8: transmit outputs hold between the ticks that drive them
  p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !(common_mode ? rx_tick : tx_tick)) |=>
      $stable(tx_chan_en) && $stable(tx_strobe));
endmodule

bind tsa_sequencer tsa_sequencer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .common_mode (common_mode),
  .rx_tick     (rx_tick),
  .tx_tick     (tx_tick),
  .rx_chan_en  (rx_chan_en),
  .rx_strobe   (rx_strobe),
  .tx_chan_en  (tx_chan_en),
  .tx_strobe   (tx_strobe)
);

// File: tb/tsa_sequencer_test.sv
module tsa_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int AW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, common_mode = 1'b0;
  logic        rx_tick = 1'b0, rx_sync = 1'b0, tx_tick = 1'b0, tx_sync = 1'b0;
  logic        wr_valid = 1'b0, wr_dir = 1'b0;
  logic        wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [14:0] wr_data = '0;
  logic [15:0] rx_chan_en, tx_chan_en;
  logic [3:0]  rx_strobe, tx_strobe;
  logic        rx_multi, rx_swtab, tx_multi, tx_swtab;

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R9";

  // reference model state
  logic [14:0] tbl [2][DEPTH];
  logic [9:0]  q0 [$];
  logic [9:0]  q1 [$];
  logic [9:0]  cur [2];

  tsa_sequencer #(.DEPTH(DEPTH), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .common_mode(common_mode),
    .rx_tick(rx_tick), .rx_sync(rx_sync), .tx_tick(tx_tick), .tx_sync(tx_sync),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_dir(wr_dir),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .rx_chan_en(rx_chan_en), .rx_strobe(rx_strobe), .rx_multi(rx_multi), .rx_swtab(rx_swtab),
    .tx_chan_en(tx_chan_en), .tx_strobe(tx_strobe), .tx_multi(tx_multi), .tx_swtab(tx_swtab)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // R1 word layout
  function automatic logic [14:0] mk(input bit m, input bit s, input logic [3:0] ss,
                                     input logic [3:0] cs, input logic [2:0] c,
                                     input bit b, input bit l);
    return {m, s, ss, cs, c, b, l};
  endfunction

  // expected outputs {chan_en, strobe, multi, swtab} from a per-tick record
  function automatic logic [21:0] expect_of(input logic [9:0] r);
    logic [15:0] ch;
    ch = (r[3:0] == 4'd0) ? 16'd0 : (16'd1 << r[3:0]);
    return {ch, r[7:4], r[9], r[8]};
  endfunction

  // expand a table into one record per tick until the last entry
  task automatic build(input int d);
    if (d == 0) q0.delete(); else q1.delete();
    for (int e = 0; e < DEPTH; e++) begin
      logic [14:0] w;
      int len;
      w = tbl[d][e];
      len = (int'(w[4:2]) + 1) * (w[1] ? 8 : 1);
      for (int k = 0; k < len; k++) begin
        if (d == 0) q0.push_back({w[14], w[13], w[12:9], w[8:5]});
        else        q1.push_back({w[14], w[13], w[12:9], w[8:5]});
      end
      if (w[0]) break;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q0.delete(); q1.delete(); cur[0] = '0; cur[1] = '0;
    end else begin
      for (int d = 0; d < 2; d++) begin
        bit tk, sy;
        tk = (d == 0 || common_mode) ? rx_tick : tx_tick;
        sy = (d == 0 || common_mode) ? rx_sync : tx_sync;
        if (!enable) begin
          if (d == 0) q0.delete(); else q1.delete();
          cur[d] = '0;
        end else if (tk) begin
          if (sy) build(d);
          if (d == 0) cur[d] = (q0.size() > 0) ? q0.pop_front() : 10'd0;
          else        cur[d] = (q1.size() > 0) ? q1.pop_front() : 10'd0;
        end
      end
    end
  end

  task automatic chk(input string t, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", t, what, act, exp, $time);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(tag, "rx", {10'd0, rx_chan_en, rx_strobe, rx_multi, rx_swtab}, {10'd0, expect_of(cur[0])});
      chk(tag, "tx", {10'd0, tx_chan_en, tx_strobe, tx_multi, tx_swtab}, {10'd0, expect_of(cur[1])});
    end
  end

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input bit d, input int a, input logic [14:0] v);
    wr_valid = 1'b1; wr_dir = d; wr_addr = AW'(a); wr_data = v;
    step();
    wr_valid = 1'b0;
    tbl[d][a] = v;
  endtask

  // n ticks; sync on the first for rx/tx as asked; gap idle clocks after each tick
  task automatic bits(input int n, input bit rs, input bit ts, input bit txon, input int gap);
    for (int i = 0; i < n; i++) begin
      rx_tick = 1'b1; rx_sync = rs && (i == 0);
      tx_tick = txon; tx_sync = ts && (i == 0) && txon;
      step();
      rx_tick = 1'b0; rx_sync = 1'b0; tx_tick = 1'b0; tx_sync = 1'b0;
      repeat (gap) step();
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    for (int d = 0; d < 2; d++) for (int e = 0; e < DEPTH; e++) tbl[d][e] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    chk("R9", "reset rx_chan_en", {16'd0, rx_chan_en}, 32'd0);
    chk("R9", "reset ready", {31'd0, wr_ready}, 32'd1);

    // R1, R7: six-entry frame written to both tables
    tag = "R1";
    for (int d = 0; d < 2; d++) begin
      wr(d[0], 0, mk(0, 0, 4'b0000, 4'd2, 3'd0, 1, 0));
      wr(d[0], 1, mk(0, 0, 4'b1000, 4'd1, 3'd0, 0, 0));
      wr(d[0], 2, mk(0, 0, 4'b0000, 4'd0, 3'd0, 0, 0));
      wr(d[0], 3, mk(0, 0, 4'b0100, 4'd0, 3'd3, 0, 0));
      wr(d[0], 4, mk(0, 0, 4'b0000, 4'd5, 3'd3, 0, 0));
      wr(d[0], 5, mk(0, 0, 4'b1000, 4'd1, 3'd0, 0, 1));
    end

    // R7, R8, R5: common mode, tx ticks held low
    common_mode = 1'b1; enable = 1'b1; step();
    chk("R9", "ready while enabled", {31'd0, wr_ready}, 32'd0);
    tag = "R7";
    bits(1, 1, 0, 0, 0);
    chk("R5", "entry0 channel 2", {16'd0, rx_chan_en}, 32'h4);
    chk("R8", "tx follows rx", {16'd0, tx_chan_en}, 32'h4);
    bits(18, 0, 0, 0, 0);
    chk("R7", "last slot chan1+strobe1", {12'd0, rx_chan_en, rx_strobe}, {12'd0, 16'h2, 4'b1000});
    tag = "R6";
    bits(5, 0, 0, 0, 1);
    chk("R6", "idle after last", {12'd0, rx_chan_en, rx_strobe}, 32'd0);

    // R9: a write offered while enabled is held back, not stored
    tag = "R9";
    wr_valid = 1'b1; wr_dir = 1'b0; wr_addr = '0; wr_data = mk(1, 1, 4'hF, 4'hF, 3'd7, 1, 1);
    repeat (3) step();
    chk("R9", "back-pressure", {31'd0, wr_ready}, 32'd0);
    wr_valid = 1'b0;
    bits(21, 1, 0, 0, 0);
    enable = 1'b0; step();
    bits(4, 1, 1, 1, 0);

    // R2, R4, R1: separate tx table with byte slots, strobes and flags
    common_mode = 1'b0;
    tag = "R2";
    wr(1, 0, mk(1, 0, 4'b0011, 4'hF, 3'd1, 1, 0));
    wr(1, 1, mk(0, 1, 4'b1000, 4'h5, 3'd2, 0, 1));
    enable = 1'b1; step();
    bits(12, 1, 0, 1, 1);
    tag = "R4";
    bits(25, 0, 1, 1, 2);

    // R11: mid-frame syncs restart both walkers
    tag = "R11";
    bits(5, 1, 1, 1, 0);
    bits(6, 1, 0, 1, 0);
    chk("R11", "tx restarted slot", {16'd0, tx_chan_en}, 32'h8000);
    bits(22, 0, 0, 1, 0);

    // R10: ticks spaced apart
    tag = "R10";
    bits(10, 1, 1, 1, 3);

    // R6: no last flag, frame ends at the final address
    enable = 1'b0; step();
    wr(0, 5, mk(0, 0, 4'b0001, 4'd1, 3'd0, 0, 0));
    enable = 1'b1; step();
    tag = "R6";
    bits(34, 1, 0, 1, 0);
    chk("R6", "idle past final address", {16'd0, rx_chan_en}, 32'd0);

    step();
    finish_up();
  end
endmodule